// File: doc/BRIEF.md
# Channel Record Termination Controller

This block decides what an I/O channel does when a transfer comes to an end. At connect time it latches a transfer function, a direction, whether word-interlaced memory transfer is engaged, and two interrupt enables. It then watches four event inputs: end of record from the device, word count reaching zero, the output buffer draining, and a terminate-output request from software. For each event it chooses one or more outcomes. It can disconnect the channel, park it in an interrecord state for the next record, or ask the device to write an end of record. It also raises zero-count and end-of-record interrupt pulses.

The transfer function is a 3-bit code. Bit 2 set marks an extended function, bit 1 marks the signal functions and bit 0 marks the proceed functions. The codes are: compatible `000` (any code with bit 2 clear behaves as compatible), read-disconnect `100`, read-proceed `101`, signal-disconnect `110` and signal-proceed `111`. Every pulse output is registered and appears for one cycle, on the clock edge that follows the triggering input.

Top module: `chan_term_ctrl`

## Requirements
- R1: While reset is held, and on the cycle after it is released, every pulse output and every level output is 0.
- R2: A connect latches the function, the direction, the enables and the interlace setting. It sets `connected`, loads `ilace` from `conn_ilace`, and clears `interrec` and `top_pending`. It raises `zc_irq` if and only if `conn_out` and `irq_on` are both 1.
- R3: End of record on a connected channel clears `ilace`. It raises `eor_irq` when the function is compatible and `irq_on` is 1, or when the latched record enable is 1.
- R4: After end of record, an extended proceed function (`101`, `111`) stays connected and sets `interrec`. Every other function pulses `disc_ev` and clears `connected`.
- R5: On input with `ilace` set, a word-count-zero event clears `ilace`. It raises `zc_irq` for extended functions whose zero enable is set. Signal-disconnect also raises `eor_irq` per its record enable and disconnects.
- R6: On output with `ilace` set and a compatible function, a word-count-zero event raises `zc_irq` when `irq_on` is 1 and disconnects.
- R7: On output with `ilace` set and an extended function, a word-count-zero event raises `zc_irq` per the zero enable and clears `top_pending`. Signal-disconnect raises `eor_irq` per the record enable and disconnects. The read functions pulse `wreor_req`, and signal-proceed pulses it only when a terminate was pending.
- R8: A terminate request on a connected output channel sets `top_pending` if `buf_busy` or `ilace` is 1. Otherwise it pulses `wreor_req`.
- R9: A buffer drain on an output channel with `ilace` clear consumes a pending terminate by pulsing `wreor_req` and clearing `top_pending`. With nothing pending, it raises `zc_irq` when `irq_on` is 1.
- R10: Events are ignored when the channel is not connected. A terminate request on an input channel, a drain while `ilace` is set, and a word-count-zero while `ilace` is clear are also ignored.
- R11: Within one cycle, a connect takes precedence over all events. After connect the order is end of record, then word-count-zero, then buffer drain, then terminate.
- R12: Each pulse lasts exactly one cycle when its triggering input is held for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conn_go | input | 1 | Connect a device, latching the fields below |
| conn_fn | input | 3 | Transfer function code |
| conn_out | input | 1 | 1 = output direction |
| conn_ilace | input | 1 | Interlace engaged at connect |
| en_zero | input | 1 | Zero-count interrupt enable |
| en_rec | input | 1 | End-of-record interrupt enable |
| irq_on | input | 1 | Program interrupts enabled (live) |
| rec_end | input | 1 | End of record from device |
| cnt_zero | input | 1 | Word count reached zero |
| buf_drain | input | 1 | Output buffer just emptied |
| buf_busy | input | 1 | Output buffer holds data |
| term_req | input | 1 | Terminate-output request |
| zc_irq | output | 1 | Zero-count / end-of-word interrupt pulse |
| eor_irq | output | 1 | End-of-record interrupt pulse |
| wreor_req | output | 1 | Write-end-of-record request pulse |
| disc_ev | output | 1 | Disconnect pulse |
| connected | output | 1 | Channel connected |
| interrec | output | 1 | Waiting between records |
| ilace | output | 1 | Interlace active |
| top_pending | output | 1 | Deferred terminate held |

## Verification
The main check walks every transfer function through each of the four events, in both directions. Enables and `irq_on` are set on some rows and cleared on others, so each row shows whether an interrupt comes from the compatible `irq_on` path or from a latched enable. Rows with and without a prior deferred terminate separate the signal-proceed and read behaviours at word-count zero. The terminate rows vary `buf_busy` and interlace to separate deferral from an immediate write end of record. Directed cases cover disconnected-channel inputs, two events in the same cycle, and a connect that arrives together with an event.

// File: rtl/chan_term_ctrl.sv
module chan_term_ctrl #(
  parameter int FN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            conn_go,
  input  logic [FN_W-1:0] conn_fn,
  input  logic            conn_out,
  input  logic            conn_ilace,
  input  logic            en_zero,
  input  logic            en_rec,
  input  logic            irq_on,
  input  logic            rec_end,
  input  logic            cnt_zero,
  input  logic            buf_drain,
  input  logic            buf_busy,
  input  logic            term_req,
  output logic            zc_irq,
  output logic            eor_irq,
  output logic            wreor_req,
  output logic            disc_ev,
  output logic            connected,
  output logic            interrec,
  output logic            ilace,
  output logic            top_pending
);

  localparam int B_PROC = 0;
  localparam int B_SIG  = 1;
  localparam int B_EXT  = FN_W - 1;

  logic [FN_W-1:0] fn_q;
  logic            out_q, enz_q, enr_q;

  logic is_ext, is_proc, is_sig, sig_disc;
  assign is_ext   = fn_q[B_EXT];
  assign is_proc  = is_ext & fn_q[B_PROC];
  assign is_sig   = is_ext & fn_q[B_SIG];
  assign sig_disc = is_sig & ~fn_q[B_PROC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fn_q        <= '0;
      out_q       <= 1'b0;
      enz_q       <= 1'b0;
      enr_q       <= 1'b0;
      connected   <= 1'b0;
      interrec    <= 1'b0;
      ilace       <= 1'b0;
      top_pending <= 1'b0;
      zc_irq      <= 1'b0;
      eor_irq     <= 1'b0;
      wreor_req   <= 1'b0;
      disc_ev     <= 1'b0;
    end else begin
      zc_irq    <= 1'b0;
      eor_irq   <= 1'b0;
      wreor_req <= 1'b0;
      disc_ev   <= 1'b0;
      if (conn_go) begin
        fn_q        <= conn_fn;
        out_q       <= conn_out;
        enz_q       <= en_zero;
        enr_q       <= en_rec;
        connected   <= 1'b1;
        interrec    <= 1'b0;
        ilace       <= conn_ilace;
        top_pending <= 1'b0;
        zc_irq      <= conn_out & irq_on;
      end else if (connected) begin
        if (rec_end) begin
          ilace   <= 1'b0;
          eor_irq <= (~is_ext & irq_on) | enr_q;
          if (is_proc) begin
            interrec <= 1'b1;
          end else begin
            connected <= 1'b0;
            disc_ev   <= 1'b1;
          end
        end else if (cnt_zero && ilace) begin
          ilace <= 1'b0;
          if (!out_q) begin
            zc_irq <= is_ext & enz_q;
            if (sig_disc) begin
              eor_irq   <= enr_q;
              connected <= 1'b0;
              disc_ev   <= 1'b1;
            end
          end else if (!is_ext) begin
            zc_irq    <= irq_on;
            connected <= 1'b0;
            disc_ev   <= 1'b1;
          end else begin
            zc_irq      <= enz_q;
            top_pending <= 1'b0;
            if (sig_disc) begin
              eor_irq   <= enr_q;
              connected <= 1'b0;
              disc_ev   <= 1'b1;
            end else if (!is_sig || top_pending) begin
              wreor_req <= 1'b1;
            end
          end
        end else if (buf_drain && out_q && !ilace) begin
          if (top_pending) begin
            top_pending <= 1'b0;
            wreor_req   <= 1'b1;
          end else begin
            zc_irq <= irq_on;
          end
        end else if (term_req && out_q) begin
          if (buf_busy || ilace) top_pending <= 1'b1;
          else                   wreor_req   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/chan_term_ctrl_chk.sv
module chan_term_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conn_go,
  input logic [2:0] conn_fn,
  input logic       conn_out,
  input logic       conn_ilace,
  input logic       en_zero,
  input logic       en_rec,
  input logic       irq_on,
  input logic       rec_end,
  input logic       cnt_zero,
  input logic       buf_drain,
  input logic       buf_busy,
  input logic       term_req,
  input logic       zc_irq,
  input logic       eor_irq,
  input logic       wreor_req,
  input logic       disc_ev,
  input logic       connected,
  input logic       interrec,
  input logic       ilace,
  input logic       top_pending
);

  assert_disc_drops_conn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disc_ev |-> (!connected && $past(connected)));

  assert_interrec_after_rec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(interrec) |-> ($past(rec_end) && connected));

  assert_eor_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eor_irq |-> $past(rec_end || cnt_zero));

  assert_wreor_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wreor_req |-> ($past(term_req || cnt_zero || buf_drain) && connected));

  assert_top_from_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(top_pending) |-> $past(term_req));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(connected) && !$past(conn_go)) |-> !(zc_irq || eor_irq || wreor_req || disc_ev));

  assert_ilace_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ilace) |-> $past(rec_end || cnt_zero || conn_go));

endmodule

bind chan_term_ctrl chan_term_ctrl_chk u_chk (.*);

// File: tb/sim_chan_term_ctrl.sv
module sim_chan_term_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conn_go = 0, conn_out = 0, conn_ilace = 0, en_zero = 0, en_rec = 0, irq_on = 0;
  logic [2:0] conn_fn = 3'b000;
  logic rec_end = 0, cnt_zero = 0, buf_drain = 0, buf_busy = 0, term_req = 0;
  logic zc_irq, eor_irq, wreor_req, disc_ev, connected, interrec, ilace, top_pending;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chan_term_ctrl u0 (.*);

  // fn(3) out il enz enr irq | ev(2) busy pre | zc eor wr disc conn inter il top
  // ev: 0 end of record, 1 count zero, 2 drain, 3 terminate
  localparam int NV = 26;
  localparam logic [19:0] VEC [NV] = '{
    20'b000_01001_0000_01010000,
    20'b000_01000_0000_00010000,
    20'b101_01010_0000_01001100,
    20'b111_10000_0000_00001100,
    20'b100_01011_0000_01010000,
    20'b100_01110_0100_10001000,
    20'b110_01110_0100_11010000,
    20'b110_01000_0100_00010000,
    20'b000_01111_0100_00001000,
    20'b000_11001_0100_10010000,
    20'b000_11000_0100_00010000,
    20'b100_11100_0100_10101000,
    20'b101_11000_0100_00101000,
    20'b111_11000_0100_00001000,
    20'b111_11000_0101_00101000,
    20'b110_11110_0101_11010000,
    20'b100_10000_1110_00001001,
    20'b100_10000_1100_00101000,
    20'b100_11000_1100_00001011,
    20'b100_10001_1001_00101000,
    20'b100_10001_1000_10001000,
    20'b100_10000_1000_00001000,
    20'b100_00000_1100_00001000,
    20'b100_11000_1000_00001010,
    20'b110_00110_0100_00001000,
    20'b111_11110_0001_01001101
  };

  function automatic logic [7:0] outs();
    return {zc_irq, eor_irq, wreor_req, disc_ev, connected, interrec, ilace, top_pending};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic connect(input logic [2:0] f, input logic o, input logic il,
                         input logic z, input logic r, input logic q);
    conn_go = 1; conn_fn = f; conn_out = o; conn_ilace = il;
    en_zero = z; en_rec = r; irq_on = q;
    step();
    conn_go = 0;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    check(outs(), 8'b0, "R1 in reset");
    rst_n = 1;
    step();
    check(outs(), 8'b0, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      string tag;
      v = VEC[i];
      connect(v[19:17], v[16], v[15], v[14], v[13], v[12]);
      check({zc_irq, connected, ilace, interrec, top_pending},
            {v[16] & v[12], 1'b1, v[15], 1'b0, 1'b0}, "R2 connect");
      if (v[8]) begin
        term_req = 1; buf_busy = 1;
        step();
        term_req = 0; buf_busy = 0;
      end
      case (v[11:10])
        2'd0: begin rec_end = 1; tag = "R3 R4 row"; end
        2'd1: begin cnt_zero = 1;
          tag = !v[16] ? "R5 row" : (v[19:17] == 3'b000 ? "R6 row" : "R7 row"); end
        2'd2: begin buf_drain = 1; tag = "R9 row"; end
        default: begin term_req = 1; buf_busy = v[9];
          tag = v[16] ? "R8 row" : "R10 row"; end
      endcase
      step();
      rec_end = 0; cnt_zero = 0; buf_drain = 0; term_req = 0; buf_busy = 0;
      check(outs(), v[7:0], $sformatf("%s %0d", tag, i));
      step();
      check(outs() & 8'hF0, 8'h00, $sformatf("R12 pulse width %0d", i));
    end

    // R10: disconnected channel ignores every event
    connect(3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    rec_end = 1; step(); rec_end = 0;
    check(outs(), 8'b01010000, "R4 compatible disconnect");
    rec_end = 1; step(); rec_end = 0;
    check(outs(), 8'b0, "R10 idle rec_end");
    cnt_zero = 1; step(); cnt_zero = 0;
    check(outs(), 8'b0, "R10 idle cnt_zero");
    buf_drain = 1; step(); buf_drain = 0;
    check(outs(), 8'b0, "R10 idle drain");
    term_req = 1; step(); term_req = 0;
    check(outs(), 8'b0, "R10 idle terminate");

    // R11: end of record outranks count zero in the same cycle
    connect(3'b110, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    rec_end = 1; cnt_zero = 1; step(); rec_end = 0; cnt_zero = 0;
    check(outs(), 8'b01010000, "R11 rec over zero");

    // R11: connect outranks an event arriving with it
    connect(3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    conn_go = 1; rec_end = 1; step(); conn_go = 0; rec_end = 0;
    check(outs(), 8'b00001010, "R11 connect over event");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule